// File: doc/BRIEF.md
# Byte-Wide Bus Slave with Top-of-Space Register Window

This block sits behind a byte-wide asynchronous memory bus and handles the slave side of it on a fast system clock. It receives active-low chip-enable, write-enable and output-enable strobes, a 19-bit address and the inbound data byte. Each of these passes through a two-flop synchronizer. A small state machine then decides what kind of access is in progress. The sixteen highest addresses, 7FFF0h to 7FFFFh, are served by an internal bank of sixteen 8-bit registers. Every other address is passed to an external SRAM through a gated chip-enable and output-enable pair.

A write exists only while chip enable and write enable are both low. It therefore starts when the later of the two strobes falls and ends when the earlier one rises. The register write is committed on the cycle that leaves the write state. It uses the address and data that were present in the last cycle of the write. Reads from the window drive the selected register onto the outbound data lines and raise a drive-enable for the pad tristate. The drive-enable is dropped as soon as a write begins.

The controller has five states: IDLE, RD_INT (window read), RD_EXT (external read), WR_INT (window write) and WR_EXT (external write). On every clock it moves to the state given by the synchronized strobes:
- IDLE whenever chip enable is high, or when both write enable and output enable are high.
- WR_INT or WR_EXT when chip enable and write enable are low, chosen by the window.
- RD_INT or RD_EXT when chip enable and output enable are low and write enable is high, chosen by the window.

Leaving WR_INT performs the commit.

Top module: `bytebus_window_slave`

## Requirements
- R1: While reset is held low, and directly after it, every register reads 0, `ext_ce_n` and `ext_oe_n` are 1 and `dq_drive` is 0.
- R2: A write whose address falls in 7FFF0h..7FFFFh, ended by write enable rising, stores the data byte in the register selected by address bits [3:0].
- R3: A write ended by chip enable rising first is also committed. The write begins only once both strobes are low, whichever of the two fell first.
- R4: The data committed is the value present before the terminating strobe edge. A data change that arrives together with that edge is not stored.
- R5: Accesses inside the window never pull `ext_ce_n` or `ext_oe_n` low.
- R6: A read outside the window, with chip enable and output enable low and write enable high, drives `ext_ce_n` = 0 and `ext_oe_n` = 0 and keeps `dq_drive` at 0.
- R7: A write outside the window drives `ext_ce_n` = 0 and `ext_oe_n` = 1 and leaves every internal register unchanged.
- R8: A window read with chip enable and output enable low and write enable high sets `dq_drive` = 1 and places the selected register on `dq_out`. With output enable high, `dq_drive` stays 0.
- R9: When write enable falls during a window read, `dq_drive` drops to 0, and `dq_drive` is 0 throughout every write.
- R10: A strobe change sampled at clock edge k appears at the outputs after edge k+2, not earlier.
- R11: Write enable low with chip enable high causes no write and no external enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_ce_n | input | 1 | Asynchronous chip enable, active low |
| bus_we_n | input | 1 | Asynchronous write enable, active low |
| bus_oe_n | input | 1 | Asynchronous output enable, active low |
| bus_addr | input | 19 | Bus address |
| dq_in | input | 8 | Inbound data byte from the pad |
| dq_out | output | 8 | Outbound data byte to the pad |
| dq_drive | output | 1 | Pad output enable; 1 drives `dq_out` |
| ext_ce_n | output | 1 | Gated external SRAM chip enable, active low |
| ext_oe_n | output | 1 | Gated external SRAM output enable, active low |

## Verification
The assertions assume the bus master keeps the address and data stable across the whole of a strobe-low interval. Under that assumption the synchronized address seen by the controller matches the state it entered, and a commit always targets the window. The stimulus honours this: it changes address and data only while both strobes are high. The one exception is the deliberate data change in the R4 test, which coincides with the terminating edge. Each phase is held for at least three clock cycles, so that the two-stage synchronizer never sees a glitch shorter than its latency.

// File: rtl/bwin_pkg.sv
package bwin_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RD_INT = 3'd1,
        ST_RD_EXT = 3'd2,
        ST_WR_INT = 3'd3,
        ST_WR_EXT = 3'd4
    } bus_state_t;

endpackage

// File: rtl/bwin_sync.sv
module bwin_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // Two flop stages; the first may go metastable, the second is used.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/bwin_ctrl.sv
module bwin_ctrl
    import bwin_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic we_n,
    input  logic oe_n,
    input  logic in_win,
    output logic commit,
    output logic drive,
    output logic ext_ce_n,
    output logic ext_oe_n
);
    bus_state_t state_q, state_d;

    // Next state follows the synchronized strobes every cycle.
    always_comb begin
        state_d = ST_IDLE;
        if (ce_n) begin
            state_d = ST_IDLE;
        end else if (!we_n) begin
            state_d = in_win ? ST_WR_INT : ST_WR_EXT;
        end else if (!oe_n) begin
            state_d = in_win ? ST_RD_INT : ST_RD_EXT;
        end else begin
            state_d = ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Moore outputs plus the commit pulse on leaving a window write.
    always_comb begin
        commit   = 1'b0;
        drive    = 1'b0;
        ext_ce_n = 1'b1;
        ext_oe_n = 1'b1;
        unique case (state_q)
            ST_IDLE: ;
            ST_RD_INT: drive = 1'b1;
            ST_RD_EXT: begin
                ext_ce_n = 1'b0;
                ext_oe_n = 1'b0;
            end
            ST_WR_INT: commit = (state_d != ST_WR_INT);
            ST_WR_EXT: ext_ce_n = 1'b0;
            default: ;
        endcase
    end

    assert_drive_off_on_we_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_n) |=> !drive)
        else $error("drive still on after write enable fell");

    assert_commit_on_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (we_n || ce_n))
        else $error("commit while both strobes still low");

    assert_no_ext_on_lone_we_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n && $past(ce_n)) |-> (ext_ce_n && !drive))
        else $error("activity with chip enable high");
endmodule

// File: rtl/bwin_regbank.sv
module bwin_regbank #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0][DATA_W-1:0] regs;

    for (genvar g = 0; g < DEPTH; g++) begin : g_reg
        logic [DATA_W-1:0] val_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              val_q <= '0;
            else if (wr_en && (wr_idx == IDX_W'(g)))  val_q <= wr_data;
        end
        assign regs[g] = val_q;
    end

    assign rd_data = regs[rd_idx];

    assert_commit_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (regs[$past(wr_idx)] == $past(wr_data)))
        else $error("committed byte not stored");
endmodule

// File: rtl/bytebus_window_slave.sv
module bytebus_window_slave #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_ce_n,
    input  logic              bus_we_n,
    input  logic              bus_oe_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_drive,
    output logic              ext_ce_n,
    output logic              ext_oe_n
);
    localparam int PIPE_W = ADDR_W + DATA_W;

    logic [2:0]        strb_s;
    logic [PIPE_W-1:0] ad_s;
    logic [ADDR_W-1:0] addr_s, addr_q;
    logic [DATA_W-1:0] din_s, din_q;
    logic              in_win;
    logic              commit, drive;
    logic [DATA_W-1:0] rd_data;

    bwin_sync #(.W(3), .RST_VAL(3'b111)) u_sync_strb (
        .clk(clk), .rst_n(rst_n),
        .d({bus_ce_n, bus_we_n, bus_oe_n}),
        .q(strb_s)
    );

    bwin_sync #(.W(PIPE_W), .RST_VAL('0)) u_sync_data (
        .clk(clk), .rst_n(rst_n),
        .d({bus_addr, dq_in}),
        .q(ad_s)
    );

    assign addr_s = ad_s[PIPE_W-1:DATA_W];
    assign din_s  = ad_s[DATA_W-1:0];
    assign in_win = &addr_s[ADDR_W-1:IDX_W];

    // Address and data aligned with the controller state.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            din_q  <= '0;
        end else begin
            addr_q <= addr_s;
            din_q  <= din_s;
        end
    end

    bwin_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .ce_n(strb_s[2]), .we_n(strb_s[1]), .oe_n(strb_s[0]),
        .in_win(in_win),
        .commit(commit), .drive(drive),
        .ext_ce_n(ext_ce_n), .ext_oe_n(ext_oe_n)
    );

    bwin_regbank #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(commit),
        .wr_idx(addr_q[IDX_W-1:0]),
        .wr_data(din_q),
        .rd_idx(addr_q[IDX_W-1:0]),
        .rd_data(rd_data)
    );

    assign dq_drive = drive;
    assign dq_out   = drive ? rd_data : '0;

    assert_window_no_ext_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_ce_n |-> !(&addr_q[ADDR_W-1:IDX_W]))
        else $error("external enable inside window");

    assert_ext_oe_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_oe_n |-> (!ext_ce_n && !dq_drive))
        else $error("external output enable without chip enable");

    assert_drive_in_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dq_drive |-> (&addr_q[ADDR_W-1:IDX_W]))
        else $error("driving for an address outside window");
endmodule

// File: tb/bytebus_window_slave_tb.sv
`timescale 1ns/1ps
module bytebus_window_slave_tb;
    localparam logic [18:0] WIN = 19'h7FFF0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [18:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dq_out;
    logic        dq_drive, ext_ce_n, ext_oe_n;
    int          n_run = 0, n_fail = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    bytebus_window_slave u_dut (
        .clk(clk), .rst_n(rst_n),
        .bus_ce_n(ce_n), .bus_we_n(we_n), .bus_oe_n(oe_n),
        .bus_addr(addr), .dq_in(din),
        .dq_out(dq_out), .dq_drive(dq_drive),
        .ext_ce_n(ext_ce_n), .ext_oe_n(ext_oe_n)
    );

    function automatic logic [7:0] pat_a(input int i);
        return 8'((i * 29 + 60) & 255);
    endfunction

    function automatic logic [7:0] pat_b(input int i);
        return pat_a(i) ^ 8'hA5;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic go_idle();
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        settle();
    endtask

    task automatic do_write(input logic [18:0] a, input logic [7:0] d,
                            input bit end_by_ce, input bit we_first, input bit exp_ext_ce);
        @(negedge clk);
        addr = a; din = d; oe_n = 1'b1;
        if (we_first) begin
            we_n = 1'b0; settle();
            chk("R3 no write before both low", {31'd0, ext_ce_n}, 32'd1);
            ce_n = 1'b0;
        end else begin
            ce_n = 1'b0; settle();
            we_n = 1'b0;
        end
        settle();
        chk("R5/R7 ext_ce_n during write", {31'd0, ext_ce_n}, {31'd0, exp_ext_ce});
        chk("R7 ext_oe_n during write", {31'd0, ext_oe_n}, 32'd1);
        chk("R9 no drive during write", {31'd0, dq_drive}, 32'd0);
        if (end_by_ce) ce_n = 1'b1; else we_n = 1'b1;
        din = ~d;                      // R4: change arrives with the terminating edge
        settle();
        ce_n = 1'b1; we_n = 1'b1;
        settle();
    endtask

    task automatic do_read_int(input int idx, input logic [7:0] exp, input string tag);
        @(negedge clk);
        addr = WIN | 19'(idx); ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        settle();
        chk({tag, " drive"}, {31'd0, dq_drive}, 32'd1);
        chk({tag, " data"}, {24'd0, dq_out}, {24'd0, exp});
        chk("R5 ext_ce_n on window read", {31'd0, ext_ce_n}, 32'd1);
        go_idle();
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk("R1 ext_ce_n in reset", {31'd0, ext_ce_n}, 32'd1);
        chk("R1 ext_oe_n in reset", {31'd0, ext_oe_n}, 32'd1);
        chk("R1 dq_drive in reset", {31'd0, dq_drive}, 32'd0);
        rst_n = 1'b1;
        settle();
        for (int i = 0; i < 16; i++) do_read_int(i, 8'h00, "R1 reset value");

        // R2 / R4: write-enable terminated sweep, both strobe orders
        for (int i = 0; i < 16; i++) do_write(WIN | 19'(i), pat_a(i), 1'b0, i[0], 1'b1);
        for (int i = 0; i < 16; i++) do_read_int(i, pat_a(i), "R2 we-ended write");

        // R3 / R4: chip-enable terminated sweep
        for (int i = 0; i < 16; i++) do_write(WIN | 19'(i), pat_b(i), 1'b1, ~i[0], 1'b1);
        for (int i = 0; i < 16; i++) do_read_int(i, pat_b(i), "R3 ce-ended write");

        // R10: latency of two synchronizer stages
        @(negedge clk);
        addr = WIN | 19'd3; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R10 no drive after two edges", {31'd0, dq_drive}, 32'd0);
        @(posedge clk);
        @(negedge clk);
        chk("R10 drive after third edge", {31'd0, dq_drive}, 32'd1);

        // R9: write enable falls during a window read
        din = 8'h77; we_n = 1'b0;
        settle();
        chk("R9 drive off after we falls", {31'd0, dq_drive}, 32'd0);
        we_n = 1'b1;
        settle();
        chk("R9 drive back after we rises", {31'd0, dq_drive}, 32'd1);
        chk("R2 data written during read", {24'd0, dq_out}, 32'h77);
        go_idle();

        // R8: output enable high keeps bus released
        @(negedge clk);
        addr = WIN | 19'd7; ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1;
        settle();
        chk("R8 no drive with oe high", {31'd0, dq_drive}, 32'd0);
        go_idle();

        // R11: write enable alone does nothing
        @(negedge clk);
        addr = WIN | 19'd5; din = 8'hEE; we_n = 1'b0;
        settle();
        chk("R11 ext_ce_n with ce high", {31'd0, ext_ce_n}, 32'd1);
        go_idle();
        do_read_int(5, pat_b(5), "R11 register unchanged");

        // R6: reads outside the window
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            addr = (k == 0) ? 19'h00000 : (k == 1) ? 19'h7FFEF :
                   (k == 2) ? 19'h40000 : 19'h7FFE5;
            ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
            settle();
            chk("R6 ext_ce_n on external read", {31'd0, ext_ce_n}, 32'd0);
            chk("R6 ext_oe_n on external read", {31'd0, ext_oe_n}, 32'd0);
            chk("R6 no drive on external read", {31'd0, dq_drive}, 32'd0);
            go_idle();
        end

        // R7: external write leaves registers alone
        do_write(19'h12346, 8'h99, 1'b0, 1'b0, 1'b0);
        do_write(19'h7FFE6, 8'h98, 1'b1, 1'b1, 1'b0);
        do_read_int(6, pat_b(6), "R7 register untouched");

        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule